// File: doc/BRIEF.md
# General-Purpose Pin and Link LED Controller

This block manages twelve general-purpose pads. Software sets each pad as an input, a push-pull output or an open-drain output. It can also arm an edge interrupt on each input, with the edge polarity chosen per pin. The block does not model the pad itself. It hands per-pin output value, output enable, pull-up enable and input-buffer enable to a pad wrapper, and it takes the raw pad level back.

The eight lowest pins can leave general-purpose duty and act as active-low open-drain link indicators, four per network port. In that mode a 2-bit selector picks which of the port's four status inputs lights the LED. Pins 8 and 9 also serve the timestamp clock. Their synchronized levels are always offered as capture inputs, and a per-pin mode bit lets a compare event drive them in place of the data bit.

Software reaches four 32-bit registers through a simple write strobe and address, with a combinational read port. Every incoming pad level passes through a two-flop synchronizer before it is read or checked for edges.

Top module: `gpio_led_ctrl`

## Requirements
- R1: Each pin is an input when its direction bit (port register at address 1, bits 27:16) is 0. An input never enables its driver and drives 0 on its output value. With direction 1 and the open-drain bit (address 0, bits 11:0) at 0, the pin drives the data bit (address 1, bits 11:0) with output enable set.
- R2: An open-drain output enables its driver to pull low when its data bit is 0 and releases the pad (enable off) when it is 1. Its output value is always 0.
- R3: Setting an LED enable bit (address 3, bits 7:0, pins 7..0) overrides the pin's direction and data. The pin becomes an active-low open-drain output: it drives low while the chosen status is 1 and releases while it is 0. Its pull-up and input buffer are off.
- R4: LED pin k serves port k/4 and shows status input number (k/4)*4 + s. Here s is the 2-bit selector at address 3, bits 8+2k+1 : 8+2k.
- R5: A pin in general-purpose mode has its pull-up enabled. Its input buffer is enabled exactly when the pin is an input.
- R6: A change on a pad level shows in the data readback and capture outputs after exactly two rising clock edges, not one.
- R7: An interrupt status bit (address 2, bits 11:0) is set on a rising edge of the synchronized level when the pin's polarity bit (address 0, bits 27:16) is 1, and on a falling edge when it is 0. Status is set only while the pin is a general-purpose input. Writing 1 to a status bit clears it, writing 0 leaves it, and a new edge wins over a clear in the same cycle.
- R8: The interrupt output is high exactly when some status bit is set whose enable (address 2, bits 27:16, written by the same write) is 1.
- R9: Reading address 1 bits 11:0 returns the data bit for output pins and the synchronized pad level for input pins. Bits 27:16 return the direction.
- R10: The capture outputs carry the synchronized levels of pins 8 and 9. When timer-mode bit 28 (pin 8) or bit 29 (pin 9) of address 0 is set, that output pin drives the compare event input instead of its data bit.
- R11: After reset all pins are inputs with pull-up and input buffer enabled and no driver enabled. All register fields are 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address for read and write |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data (combinational) |
| pad_in_i | input | 12 | Raw pad levels |
| pad_out_o | output | 12 | Value driven to each pad |
| pad_oe_o | output | 12 | Per-pin output driver enable |
| pad_pu_o | output | 12 | Per-pin pull-up enable |
| pad_ie_o | output | 12 | Per-pin input buffer enable |
| led_stat_i | input | 8 | Link status sources, four per port |
| cmp_evt_i | input | 2 | Timestamp compare events for pins 8 and 9 |
| cap_o | output | 2 | Synchronized pin 8 and 9 levels for time capture |
| irq_o | output | 1 | Combined interrupt |

## Verification
The pad drive is tried with a table of mixed configurations. The table covers all inputs, all push-pull, all open-drain, a split of inputs and outputs, and three modes side by side in one vector. These separate a wrong direction gate, an inverted open-drain enable and a readback that takes the wrong source per pin. Edge interrupts are driven with a pin of each polarity toggled together, which separates rising from falling sensitivity. The same toggles on an output pin and on an LED pin must leave status untouched. LED tests light one status per port to expose a wrong port offset or selector decode, and the timer tests alternate the compare event against the data bit on pins 8 and 9.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [1:0] ADR_PINCFG = 2'd0;
  localparam logic [1:0] ADR_PORT   = 2'd1;
  localparam logic [1:0] ADR_IRQ    = 2'd2;
  localparam logic [1:0] ADR_LED    = 2'd3;
  localparam int FIELD_HI = 16;

  // status input feeding LED pin `pin` for a given selector value
  function automatic int led_src_idx(int pin, int sel, int per_port);
    return (pin / per_port) * per_port + sel;
  endfunction

  // edge of the requested polarity between two successive samples
  function automatic logic edge_hit(logic rise_sel, logic prev, logic cur);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // {output enable, output value} of a general-purpose output
  function automatic logic [1:0] pad_drive(logic odrain, logic val);
    return odrain ? {~val, 1'b0} : {1'b1, val};
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq
  import gpio_pkg::*;
#(
  parameter int NP = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] lvl_i,
  input  logic [NP-1:0] watch_i,
  input  logic [NP-1:0] rise_sel_i,
  input  logic          en_we_i,
  input  logic [NP-1:0] en_d_i,
  input  logic [NP-1:0] clr_i,
  output logic [NP-1:0] evt_o,
  output logic [NP-1:0] sts_o,
  output logic [NP-1:0] en_o,
  output logic          irq_o
);
  logic [NP-1:0] prev_q, sts_q, en_q;

  for (genvar k = 0; k < NP; k++) begin : g_evt
    assign evt_o[k] = watch_i[k] & edge_hit(rise_sel_i[k], prev_q[k], lvl_i[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      sts_q  <= '0;
      en_q   <= '0;
    end else begin
      prev_q <= lvl_i;
      sts_q  <= (sts_q & ~clr_i) | evt_o;
      if (en_we_i) en_q <= en_d_i;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign irq_o = |(sts_q & en_q);

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q) & ~$past(clr_i) & ~sts_q) == '0));
  // R7
  sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(evt_o) & ~sts_q) == '0));
  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(evt_o & en_q)) && !en_we_i) |=> irq_o);
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pkg::*;
(
  input  logic led_mode_i,
  input  logic led_on_i,
  input  logic dir_i,
  input  logic odrain_i,
  input  logic val_i,
  output logic oe_o,
  output logic out_o,
  output logic pu_o,
  output logic ie_o
);
  always_comb begin
    oe_o  = 1'b0;
    out_o = 1'b0;
    pu_o  = 1'b1;
    ie_o  = 1'b1;
    if (led_mode_i) begin
      oe_o = led_on_i;
      pu_o = 1'b0;
      ie_o = 1'b0;
    end else if (dir_i) begin
      {oe_o, out_o} = pad_drive(odrain_i, val_i);
      ie_o = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_led_ctrl.sv
module gpio_led_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS      = 12,
  parameter int NUM_PORTS     = 2,
  parameter int LEDS_PER_PORT = 4,
  parameter int NUM_TMR       = 2,
  parameter int TMR_BASE      = 8,
  parameter int DW            = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en_i,
  input  logic [1:0]                         addr_i,
  input  logic [DW-1:0]                      wdata_i,
  output logic [DW-1:0]                      rdata_o,
  input  logic [NUM_PINS-1:0]                pad_in_i,
  output logic [NUM_PINS-1:0]                pad_out_o,
  output logic [NUM_PINS-1:0]                pad_oe_o,
  output logic [NUM_PINS-1:0]                pad_pu_o,
  output logic [NUM_PINS-1:0]                pad_ie_o,
  input  logic [NUM_PORTS*LEDS_PER_PORT-1:0] led_stat_i,
  input  logic [NUM_TMR-1:0]                 cmp_evt_i,
  output logic [NUM_TMR-1:0]                 cap_o,
  output logic                               irq_o
);
  localparam int NP    = NUM_PINS;
  localparam int NLED  = NUM_PORTS * LEDS_PER_PORT;
  localparam int SEL_W = $clog2(LEDS_PER_PORT);
  localparam int TMR_F = FIELD_HI + NP;

  logic [NP-1:0]         odr_q, rise_q, data_q, dir_q;
  logic [NUM_TMR-1:0]    tmr_q;
  logic [NLED-1:0]       led_en_q;
  logic [NLED*SEL_W-1:0] led_sel_q;

  logic [NP-1:0] sync_lvl, led_mode, evt, sts, int_en;
  logic          irq_we;
  logic          unused_wbits;

  assign unused_wbits = ^wdata_i;
  assign irq_we = wr_en_i && (addr_i == ADR_IRQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odr_q     <= '0;
      rise_q    <= '0;
      tmr_q     <= '0;
      data_q    <= '0;
      dir_q     <= '0;
      led_en_q  <= '0;
      led_sel_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        ADR_PINCFG: begin
          odr_q  <= wdata_i[NP-1:0];
          rise_q <= wdata_i[FIELD_HI +: NP];
          tmr_q  <= wdata_i[TMR_F +: NUM_TMR];
        end
        ADR_PORT: begin
          data_q <= wdata_i[NP-1:0];
          dir_q  <= wdata_i[FIELD_HI +: NP];
        end
        ADR_LED: begin
          led_en_q  <= wdata_i[NLED-1:0];
          led_sel_q <= wdata_i[NLED +: NLED*SEL_W];
        end
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(NP)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_in_i), .q_o(sync_lvl)
  );

  gpio_irq #(.NP(NP)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl_i(sync_lvl), .watch_i(pad_ie_o),
    .rise_sel_i(rise_q), .en_we_i(irq_we), .en_d_i(wdata_i[FIELD_HI +: NP]),
    .clr_i(irq_we ? wdata_i[NP-1:0] : '0),
    .evt_o(evt), .sts_o(sts), .en_o(int_en), .irq_o(irq_o)
  );

  for (genvar k = 0; k < NP; k++) begin : g_pin
    logic lm, lo, val;
    if (k < NLED) begin : g_led
      assign lm = led_en_q[k];
      assign lo = led_stat_i[led_src_idx(k, int'(led_sel_q[k*SEL_W +: SEL_W]), LEDS_PER_PORT)];
    end else begin : g_noled
      assign lm = 1'b0;
      assign lo = 1'b0;
    end
    if (k >= TMR_BASE && k < TMR_BASE + NUM_TMR) begin : g_tmr
      assign val = tmr_q[k-TMR_BASE] ? cmp_evt_i[k-TMR_BASE] : data_q[k];
    end else begin : g_plain
      assign val = data_q[k];
    end
    assign led_mode[k] = lm;
    gpio_pin_cell u_cell (
      .led_mode_i(lm), .led_on_i(lo), .dir_i(dir_q[k]), .odrain_i(odr_q[k]),
      .val_i(val), .oe_o(pad_oe_o[k]), .out_o(pad_out_o[k]),
      .pu_o(pad_pu_o[k]), .ie_o(pad_ie_o[k])
    );
  end

  assign cap_o = sync_lvl[TMR_BASE +: NUM_TMR];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_PINCFG: begin
        rdata_o[NP-1:0]           = odr_q;
        rdata_o[FIELD_HI +: NP]   = rise_q;
        rdata_o[TMR_F +: NUM_TMR] = tmr_q;
      end
      ADR_PORT: begin
        rdata_o[NP-1:0]         = (dir_q & data_q) | (~dir_q & sync_lvl);
        rdata_o[FIELD_HI +: NP] = dir_q;
      end
      ADR_IRQ: begin
        rdata_o[NP-1:0]         = sts;
        rdata_o[FIELD_HI +: NP] = int_en;
      end
      default: begin
        rdata_o[NLED-1:0]           = led_en_q;
        rdata_o[NLED +: NLED*SEL_W] = led_sel_q;
      end
    endcase
  end

  // R1
  input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & ~led_mode & pad_oe_o) == '0));
  // R2
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe_o & pad_out_o & (odr_q | led_mode)) == '0));
  // R3
  led_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((led_mode & (pad_pu_o | pad_ie_o)) == '0));
  // R7
  out_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & ~$past(sts) & ~$past(pad_ie_o)) == '0));
endmodule

// File: tb/gpio_led_ctrl_test.sv
module gpio_led_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [11:0] pad_in_i = '0;
  logic [11:0] pad_out_o, pad_oe_o, pad_pu_o, pad_ie_o;
  logic [7:0]  led_stat_i = '0;
  logic [1:0]  cmp_evt_i = '0;
  logic [1:0]  cap_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_led_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_in_i(pad_in_i),
    .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
    .pad_ie_o(pad_ie_o), .led_stat_i(led_stat_i), .cmp_evt_i(cmp_evt_i),
    .cap_o(cap_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [11:0] dir, odr, data, pad, oe, out, ie, rd;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{12'h000, 12'h000, 12'hFFF, 12'h5A5, 12'h000, 12'h000, 12'hFFF, 12'h5A5},
    '{12'hFFF, 12'h000, 12'hA5C, 12'h000, 12'hFFF, 12'hA5C, 12'h000, 12'hA5C},
    '{12'hFFF, 12'hFFF, 12'hA5C, 12'hFFF, 12'h5A3, 12'h000, 12'h000, 12'hA5C},
    '{12'h0F0, 12'h000, 12'hFFF, 12'h123, 12'h0F0, 12'h0F0, 12'hF0F, 12'h1F3},
    '{12'hFF0, 12'hF00, 12'h3CC, 12'hFFF, 12'hCF0, 12'h0C0, 12'h00F, 12'h3CF},
    '{12'h00F, 12'h00F, 12'h00A, 12'h0F0, 12'h005, 12'h000, 12'hFF0, 12'h0FA}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk);
    #1 wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] r;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);

    // R11 reset state
    chk("R11 oe", {20'd0, pad_oe_o}, 32'h0);
    chk("R11 pu", {20'd0, pad_pu_o}, 32'hFFF);
    chk("R11 ie", {20'd0, pad_ie_o}, 32'hFFF);
    chk("R11 irq", {31'd0, irq_o}, 32'h0);
    rd(2'd0, r); chk("R11 pincfg", r, 32'h0);
    rd(2'd1, r); chk("R11 port", r, 32'h0);

    // R1 R2 R5 R9 vector walk
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {20'd0, VEC[i].odr});
      wr(2'd1, {4'd0, VEC[i].dir, 4'd0, VEC[i].data});
      pad_in_i = VEC[i].pad;
      wait_cyc(3);
      chk("R1 R2 oe", {20'd0, pad_oe_o}, {20'd0, VEC[i].oe});
      chk("R1 R2 out", {20'd0, pad_out_o}, {20'd0, VEC[i].out});
      chk("R5 ie", {20'd0, pad_ie_o}, {20'd0, VEC[i].ie});
      chk("R5 pu", {20'd0, pad_pu_o}, 32'hFFF);
      rd(2'd1, r);
      chk("R9 readback", r, {4'd0, VEC[i].dir, 4'd0, VEC[i].rd});
    end

    // R6 two-edge synchronizer latency
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    pad_in_i = 12'h000;
    wait_cyc(4);
    pad_in_i = 12'h800;
    @(posedge clk); #1;
    rd(2'd1, r); chk("R6 one edge", r, 32'h0);
    @(posedge clk); #1;
    rd(2'd1, r); chk("R6 two edges", r, 32'h800);
    pad_in_i = 12'h000;
    wait_cyc(4);

    // R7 R8 edge interrupts: pin0 rising, pin1 falling
    wr(2'd0, 32'h0001_0000);
    wr(2'd2, 32'h0001_0FFF);
    rd(2'd2, r); chk("R7 cleared", r, 32'h0001_0000);
    chk("R8 idle", {31'd0, irq_o}, 32'h0);
    pad_in_i = 12'h003;
    wait_cyc(4);
    rd(2'd2, r); chk("R7 rise", r, 32'h0001_0001);
    chk("R8 enabled status", {31'd0, irq_o}, 32'h1);
    pad_in_i = 12'h000;
    wait_cyc(4);
    rd(2'd2, r); chk("R7 fall", r, 32'h0001_0003);
    wr(2'd2, 32'h0001_0001);
    rd(2'd2, r); chk("R7 w1c", r, 32'h0001_0002);
    chk("R8 masked", {31'd0, irq_o}, 32'h0);
    wr(2'd2, 32'h0003_0000);
    rd(2'd2, r); chk("R7 zero write keeps", r, 32'h0003_0002);
    chk("R8 enable late", {31'd0, irq_o}, 32'h1);
    wr(2'd2, 32'h0003_0FFF);
    chk("R8 all clear", {31'd0, irq_o}, 32'h0);

    // R7 output pin edges ignored (pin2 output, falling-sensitive)
    wr(2'd1, 32'h0004_0000);
    pad_in_i = 12'h004; wait_cyc(4);
    pad_in_i = 12'h000; wait_cyc(4);
    rd(2'd2, r); chk("R7 output ignored", r, 32'h0003_0000);
    wr(2'd1, 32'h0);

    // R7 LED pin edges ignored (pin0, rising-sensitive)
    wr(2'd3, 32'h0000_0001);
    pad_in_i = 12'h001; wait_cyc(4);
    pad_in_i = 12'h000; wait_cyc(4);
    rd(2'd2, r); chk("R7 led ignored", r, 32'h0003_0000);
    wr(2'd3, 32'h0);

    // R3 R4 LED mode, port 0 selectors 0..3 on pins 0..3
    wr(2'd3, 32'h0000_E40F);
    led_stat_i = 8'h05;
    #1;
    chk("R4 port0 select", {20'd0, pad_oe_o}, 32'h005);
    chk("R3 led out low", {20'd0, pad_out_o}, 32'h0);
    chk("R3 pu off", {20'd0, pad_pu_o}, 32'hFF0);
    chk("R3 ie off", {20'd0, pad_ie_o}, 32'hFF0);

    // R3 R4 pin5 on port 1 with selector 2, overriding a driven output
    wr(2'd1, 32'h0020_0020);
    wr(2'd3, 32'h0008_0020);
    led_stat_i = 8'h40;
    #1;
    chk("R4 port1 select", {20'd0, pad_oe_o}, 32'h020);
    led_stat_i = 8'h04;
    #1;
    chk("R3 override off", {20'd0, pad_oe_o}, 32'h0);
    chk("R3 override out", {20'd0, pad_out_o}, 32'h0);
    wr(2'd3, 32'h0);
    led_stat_i = 8'h00;

    // R10 timer pins
    wr(2'd0, 32'h1000_0000);
    wr(2'd1, 32'h0300_0200);
    cmp_evt_i = 2'b01; #1;
    chk("R10 compare drives", {30'd0, pad_out_o[9:8]}, 32'h3);
    cmp_evt_i = 2'b00; #1;
    chk("R10 compare low", {30'd0, pad_out_o[9:8]}, 32'h2);
    cmp_evt_i = 2'b10; #1;
    chk("R10 pin9 data", {30'd0, pad_out_o[9:8]}, 32'h2);
    wr(2'd1, 32'h0);
    pad_in_i = 12'h100;
    wait_cyc(3);
    chk("R10 capture", {30'd0, cap_o}, 32'h1);

    summary();
    $finish;
  end
endmodule